// File: doc/BRIEF.md
# Regulator Startup Sequencer

This block walks a step-down regulator from off to regulating, one step per tick of a fixed timebase clock. When enable is seen, the block turns on the internal linear regulator at once. It then holds the power stage idle through a timed calibration window. At the end of that window it latches the frequency-select code. After that it releases switching and ramps a digital reference word from zero to the full-scale code at a constant rate. The ramp lasts one of four durations, chosen by the soft-start code.

The block also chooses between auto-skip and forced-continuous operation at light load. It shuts switching off while the supply or the die temperature is out of range, and it recovers from such a fault by itself. A restart request from a fault controller repeats soft-start without repeating calibration.

The state machine has five states:
- `ST_IDLE`: off.
- `ST_CAL`: calibration window, switching inhibited.
- `ST_RAMP`: soft-start ramp.
- `ST_RUN`: regulating at the full-scale reference.
- `ST_FAULT`: switching held off until both health flags return.

Its transitions are:
- idle to calibrate, on enable.
- calibrate to ramp, when the window ends with both health flags good.
- calibrate to fault, when the window ends with a health flag bad.
- ramp to run, when the reference reaches full scale.
- ramp to ramp, on a restart request.
- ramp or run to fault, on a health flag loss.
- run to ramp, on a restart request.
- fault to ramp, when both health flags are good again.
- any state to idle, when enable is low.

Top module: `buck_start_seq`

## Requirements
- R1: Out of reset, `ldo_en` is 0. `ldo_en` goes to 1 after the first clock edge at which `en` is sampled high, and it stays 1 while `en` stays high.
- R2: `sw_inhibit` is 1 out of reset. After `en` is sampled high, `sw_inhibit` stays 1 for CAL_TICKS further clock edges, then goes to 0.
- R3: At the clock edge that ends calibration, `freq_code` takes the value of `freq_sel` (three bits, eight values). It then holds that value regardless of later `freq_sel` changes. It is recaptured only by a new calibration. Its reset value is 0.
- R4: During soft-start, `ref_word` starts at 0 and rises by at most one code per clock. After k clocks it equals floor(k*REF_FULL/D). It reaches REF_FULL exactly D clocks after the ramp starts and never exceeds REF_FULL. D is BASE_TICKS shifted left by `mode_code[1:0]`, so codes 0, 1, 2 and 3 give 1x, 2x, 4x and 8x.
- R5: `ss_done` is high for exactly one cycle, the cycle in which `ref_word` first equals REF_FULL.
- R6: With `mode_code[2]`=1 (forced continuous), `fccm_en` goes to 1 one cycle after `pgood` is sampled high in the run state. It stays 1 until the run state is left. With `mode_code[2]`=0 (auto-skip), `fccm_en` stays 0.
- R7: `mode_code` is sampled only at the edge where `en` is first seen high. Changes after that do not alter the ramp duration or the light-load mode.
- R8: If `supply_ok` or `therm_ok` is low while switching, then after the next edge `sw_inhibit`=1 and `ref_word`=0. This holds while the flag is low. The fault does not latch. Once both flags are high again, the ramp restarts from 0 without recalibration, and `freq_code` is kept.
- R9: `en` sampled low in any state gives `ldo_en`=0, `sw_inhibit`=1, `ref_word`=0 and `fccm_en`=0 after that edge.
- R10: `restart_req` sampled high while ramping or running clears `ref_word` to 0 after that edge, with switching still enabled. A full ramp of duration D follows, and there is no calibration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enable request |
| supply_ok | input | 1 | Supply above its undervoltage threshold |
| therm_ok | input | 1 | Die temperature within limit |
| pgood | input | 1 | Output voltage within its power-good window |
| restart_req | input | 1 | Request from the fault controller to repeat soft-start |
| mode_code | input | 3 | Bit 2: forced continuous; bits 1:0: soft-start length |
| freq_sel | input | 3 | Switching frequency selection code |
| ldo_en | output | 1 | Enable for the internal linear regulator |
| sw_inhibit | output | 1 | High while the power stage must not switch |
| freq_code | output | 3 | Frequency code latched at calibration |
| ss_done | output | 1 | One-cycle pulse when soft-start completes |
| fccm_en | output | 1 | 1 = forced-continuous, 0 = auto-skip light-load operation |
| ref_word | output | 10 | Digital reference word for the DAC |

## Verification
The properties take all inputs to be synchronous levels sampled on the timebase clock. They also take REF_FULL to be no larger than BASE_TICKS, so that the ramp never needs more than one code per tick. Under that condition the one-step and ceiling checks are meaningful. The bench changes every input only on the falling clock edge. It instantiates the block with REF_FULL below BASE_TICKS. It holds `freq_sel` steady across the edge that closes calibration, so the captured code is known.

// File: rtl/buck_seq_pkg.sv
`timescale 1ns/1ps
package buck_seq_pkg;
    localparam int FREQ_W   = 3;
    localparam int MODE_W   = 3;
    localparam int SEL_W    = 2;
    localparam int FCCM_BIT = 2;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CAL   = 3'd1,
        ST_RAMP  = 3'd2,
        ST_RUN   = 3'd3,
        ST_FAULT = 3'd4
    } seq_state_t;
endpackage

// File: rtl/buck_cal_timer.sv
`timescale 1ns/1ps
module buck_cal_timer #(
    parameter int CAL_TICKS = 250,
    parameter int FREQ_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic [FREQ_W-1:0] freq_sel,
    output logic              done,
    output logic [FREQ_W-1:0] freq_code
);
    localparam int CNT_W = $clog2(CAL_TICKS + 1);

    logic [CNT_W-1:0] cnt;

    assign done = active && (cnt == CNT_W'(CAL_TICKS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            freq_code <= '0;
        end else begin
            if (!active || done) cnt <= '0;
            else                 cnt <= cnt + CNT_W'(1);
            if (done) freq_code <= freq_sel;
        end
    end
endmodule

// File: rtl/buck_ss_ramp.sv
`timescale 1ns/1ps
module buck_ss_ramp #(
    parameter int REF_W      = 10,
    parameter int REF_FULL   = 600,
    parameter int BASE_TICKS = 700,
    parameter int SEL_W      = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             go,
    input  logic [SEL_W-1:0] ss_sel,
    output logic [REF_W-1:0] ref_word,
    output logic             full_next
);
    localparam int N_DUR   = 1 << SEL_W;
    localparam int MAX_DUR = BASE_TICKS << (N_DUR - 1);
    localparam int ACC_W   = $clog2(MAX_DUR + REF_FULL + 1);

    logic [ACC_W-1:0] dur_tab [N_DUR];
    logic [ACC_W-1:0] acc, acc_sum, dur;
    logic             step;

    for (genvar i = 0; i < N_DUR; i++) begin : g_dur
        assign dur_tab[i] = ACC_W'(BASE_TICKS << i);
    end

    assign dur       = dur_tab[ss_sel];
    assign acc_sum   = acc + ACC_W'(REF_FULL);
    assign step      = (acc_sum >= dur);
    assign full_next = step && (ref_word == REF_W'(REF_FULL - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc      <= '0;
            ref_word <= '0;
        end else if (clr) begin
            acc      <= '0;
            ref_word <= '0;
        end else if (go) begin
            if (step) begin
                acc      <= acc_sum - dur;
                ref_word <= ref_word + REF_W'(1);
            end else begin
                acc      <= acc_sum;
            end
        end
    end
endmodule

// File: rtl/buck_start_seq.sv
`timescale 1ns/1ps
module buck_start_seq
    import buck_seq_pkg::*;
#(
    parameter int CAL_TICKS  = 250,
    parameter int BASE_TICKS = 700,
    parameter int REF_W      = 10,
    parameter int REF_FULL   = 600
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              supply_ok,
    input  logic              therm_ok,
    input  logic              pgood,
    input  logic              restart_req,
    input  logic [MODE_W-1:0] mode_code,
    input  logic [FREQ_W-1:0] freq_sel,
    output logic              ldo_en,
    output logic              sw_inhibit,
    output logic [FREQ_W-1:0] freq_code,
    output logic              ss_done,
    output logic              fccm_en,
    output logic [REF_W-1:0]  ref_word
);
    seq_state_t        state, nxt;
    logic [MODE_W-1:0] mode_q;
    logic              cal_done, full_next, health_bad;
    logic              ramp_clr, ramp_go, fresh;

    assign health_bad = !supply_ok || !therm_ok;

    buck_cal_timer #(.CAL_TICKS(CAL_TICKS), .FREQ_W(FREQ_W)) u_cal (
        .clk(clk), .rst_n(rst_n), .active(state == ST_CAL),
        .freq_sel(freq_sel), .done(cal_done), .freq_code(freq_code)
    );

    buck_ss_ramp #(.REF_W(REF_W), .REF_FULL(REF_FULL),
                   .BASE_TICKS(BASE_TICKS), .SEL_W(SEL_W)) u_ramp (
        .clk(clk), .rst_n(rst_n), .clr(ramp_clr), .go(ramp_go),
        .ss_sel(mode_q[SEL_W-1:0]), .ref_word(ref_word), .full_next(full_next)
    );

    // next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (en) nxt = ST_CAL;
            ST_CAL:   if (cal_done) nxt = health_bad ? ST_FAULT : ST_RAMP;
            ST_RAMP: begin
                if (health_bad)       nxt = ST_FAULT;
                else if (restart_req) nxt = ST_RAMP;
                else if (full_next)   nxt = ST_RUN;
            end
            ST_RUN: begin
                if (health_bad)       nxt = ST_FAULT;
                else if (restart_req) nxt = ST_RAMP;
            end
            ST_FAULT: if (!health_bad) nxt = ST_RAMP;
            default:  nxt = ST_IDLE;
        endcase
        if (!en) nxt = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // outputs and ramp control
    always_comb begin
        ldo_en     = (state != ST_IDLE);
        sw_inhibit = !((state == ST_RAMP) || (state == ST_RUN));
        fresh      = (nxt == ST_RAMP) && ((state != ST_RAMP) || restart_req);
        ramp_clr   = !((nxt == ST_RAMP) || (nxt == ST_RUN)) || fresh;
        ramp_go    = (state == ST_RAMP) && !ramp_clr;
    end

    // registered side outputs and the captured mode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= '0;
            fccm_en <= 1'b0;
            ss_done <= 1'b0;
        end else begin
            if ((state == ST_IDLE) && en) mode_q <= mode_code;
            fccm_en <= (nxt == ST_RUN) && mode_q[FCCM_BIT] && (fccm_en || pgood);
            ss_done <= (state == ST_RAMP) && (nxt == ST_RUN);
        end
    end
endmodule

// File: rtl/buck_start_seq_chk.sv
`timescale 1ns/1ps
module buck_start_seq_chk #(
    parameter int REF_W    = 10,
    parameter int REF_FULL = 600
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             supply_ok,
    input logic             therm_ok,
    input logic             pgood,
    input logic             ldo_en,
    input logic             sw_inhibit,
    input logic [2:0]       freq_code,
    input logic             ss_done,
    input logic             fccm_en,
    input logic [REF_W-1:0] ref_word
);
    AST_LDO_ON: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> ldo_en); // R1
    AST_FREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_inhibit && $past(!sw_inhibit)) |-> $stable(freq_code)); // R3
    AST_REF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_word != '0) |-> (ref_word == $past(ref_word) || ref_word == $past(ref_word) + REF_W'(1))); // R4
    AST_REF_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
        ref_word <= REF_W'(REF_FULL)); // R4
    AST_RAMP_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sw_inhibit) |-> (ref_word == '0)); // R4
    AST_DONE_AT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        ss_done |-> (ref_word == REF_W'(REF_FULL))); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ss_done |=> !ss_done); // R5
    AST_FCCM_AFTER_PG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fccm_en) |-> $past(pgood)); // R6
    AST_FCCM_SWITCHING: assert property (@(posedge clk) disable iff (!rst_n)
        fccm_en |-> !sw_inhibit); // R6
    AST_FAULT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        ((!supply_ok || !therm_ok) && !sw_inhibit) |=> (sw_inhibit && ref_word == '0)); // R8
    AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!ldo_en && sw_inhibit && ref_word == '0 && !fccm_en)); // R9
endmodule

bind buck_start_seq buck_start_seq_chk #(.REF_W(REF_W), .REF_FULL(REF_FULL)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .supply_ok(supply_ok), .therm_ok(therm_ok),
    .pgood(pgood), .ldo_en(ldo_en), .sw_inhibit(sw_inhibit), .freq_code(freq_code),
    .ss_done(ss_done), .fccm_en(fccm_en), .ref_word(ref_word)
);

// File: tb/tb_buck_start_seq.sv
`timescale 1ns/1ps
module tb_buck_start_seq;
    localparam int CAL  = 20;
    localparam int BASE = 40;
    localparam int FULL = 30;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0, supply_ok = 1'b1, therm_ok = 1'b1, pgood = 1'b0, restart_req = 1'b0;
    logic [2:0] mode_code = '0, freq_sel = '0;
    logic       ldo_en, sw_inhibit, ss_done, fccm_en;
    logic [2:0] freq_code;
    logic [9:0] ref_word;

    int n_run = 0, n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    buck_start_seq #(.CAL_TICKS(CAL), .BASE_TICKS(BASE), .REF_W(10), .REF_FULL(FULL)) dut (
        .clk(clk), .rst_n(rst_n), .en(en), .supply_ok(supply_ok), .therm_ok(therm_ok),
        .pgood(pgood), .restart_req(restart_req), .mode_code(mode_code), .freq_sel(freq_sel),
        .ldo_en(ldo_en), .sw_inhibit(sw_inhibit), .freq_code(freq_code), .ss_done(ss_done),
        .fccm_en(fccm_en), .ref_word(ref_word)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Enable, then scramble mode_code after capture (R7); ends in the first ramp cycle.
    task automatic enable_seq(input logic [2:0] mode, input logic [2:0] fsel);
        mode_code = mode; freq_sel = fsel; en = 1'b1;
        tick(1);
        mode_code = ~mode;
        tick(CAL);
        check("R2", "switching released after calibration", int'(sw_inhibit), 0);
        check("R4", "ramp starts at zero", int'(ref_word), 0);
    endtask

    task automatic ramp_profile(input int dur, input string req);
        int bad = 0, ssbad = 0;
        for (int k = 1; k <= dur; k++) begin
            tick(1);
            if (int'(ref_word) != (k * FULL) / dur) bad++;
            if (int'(ss_done) != int'(k == dur)) ssbad++;
        end
        check(req, "ramp profile mismatches", bad, 0);
        check("R5", "ss_done pulse mismatches", ssbad, 0);
        tick(1);
        check("R5", "ss_done low after pulse", int'(ss_done), 0);
        check(req, "reference held at full scale", int'(ref_word), FULL);
    endtask

    task automatic disable_seq();
        en = 1'b0;
        tick(1);
        check("R9", "ldo_en after disable", int'(ldo_en), 0);
        check("R9", "sw_inhibit after disable", int'(sw_inhibit), 1);
        check("R9", "ref_word after disable", int'(ref_word), 0);
        check("R9", "fccm_en after disable", int'(fccm_en), 0);
    endtask

    task automatic t_reset();
        check("R1", "ldo_en at reset", int'(ldo_en), 0);
        check("R2", "sw_inhibit at reset", int'(sw_inhibit), 1);
        check("R3", "freq_code at reset", int'(freq_code), 0);
        check("R4", "ref_word at reset", int'(ref_word), 0);
        check("R5", "ss_done at reset", int'(ss_done), 0);
    endtask

    task automatic t_basic();
        mode_code = 3'b000; freq_sel = 3'd5; en = 1'b1;
        tick(1);
        check("R1", "ldo_en one edge after enable", int'(ldo_en), 1);
        check("R2", "inhibit at calibration start", int'(sw_inhibit), 1);
        mode_code = 3'b111;                 // R7: ignored
        tick(CAL - 1);
        check("R2", "inhibit at last calibration cycle", int'(sw_inhibit), 1);
        tick(1);
        check("R2", "inhibit released", int'(sw_inhibit), 0);
        check("R3", "frequency code captured", int'(freq_code), 5);
        freq_sel = 3'd2;
        ramp_profile(BASE, "R7");           // mode change did not lengthen ramp
        check("R3", "frequency code held", int'(freq_code), 5);
        pgood = 1'b1;
        tick(3);
        check("R6", "auto-skip keeps fccm_en low", int'(fccm_en), 0);
        check("R1", "ldo_en held while enabled", int'(ldo_en), 1);
        pgood = 1'b0;
        disable_seq();
    endtask

    task automatic t_durations();
        for (int s = 1; s < 4; s++) begin
            enable_seq(3'(s), 3'd3);
            ramp_profile(BASE << s, "R4");
            disable_seq();
        end
    endtask

    task automatic t_fccm();
        enable_seq(3'b100, 3'd3);
        ramp_profile(BASE, "R4");
        tick(4);
        check("R6", "fccm_en low before pgood", int'(fccm_en), 0);
        pgood = 1'b1;
        tick(1);
        check("R6", "fccm_en one cycle after pgood", int'(fccm_en), 1);
        pgood = 1'b0;
        tick(2);
        check("R6", "fccm_en held after pgood drops", int'(fccm_en), 1);
        check("R7", "mode scramble did not clear fccm", int'(fccm_en), 1);
        disable_seq();
    endtask

    task automatic t_fault();
        enable_seq(3'b000, 3'd4);
        ramp_profile(BASE, "R4");
        freq_sel = 3'd6;
        supply_ok = 1'b0;
        tick(1);
        check("R8", "inhibit on supply loss", int'(sw_inhibit), 1);
        check("R8", "reference cleared on supply loss", int'(ref_word), 0);
        tick(5);
        check("R8", "inhibit held during fault", int'(sw_inhibit), 1);
        supply_ok = 1'b1;
        tick(1);
        check("R8", "switching resumes after fault", int'(sw_inhibit), 0);
        check("R8", "ramp restarts at zero", int'(ref_word), 0);
        check("R8", "no recalibration", int'(freq_code), 4);
        ramp_profile(BASE, "R8");
        therm_ok = 1'b0;
        tick(1);
        check("R8", "inhibit on thermal fault", int'(sw_inhibit), 1);
        therm_ok = 1'b1;
        tick(1);
        check("R8", "thermal fault not latched", int'(sw_inhibit), 0);
        disable_seq();
    endtask

    task automatic t_restart();
        enable_seq(3'b001, 3'd1);
        tick(10);
        restart_req = 1'b1;
        tick(1);
        restart_req = 1'b0;
        check("R10", "reference cleared by restart", int'(ref_word), 0);
        check("R10", "switching kept on restart", int'(sw_inhibit), 0);
        ramp_profile(BASE << 1, "R10");
        check("R10", "frequency code kept", int'(freq_code), 1);
        disable_seq();
    endtask

    task automatic t_abort();
        freq_sel = 3'd7; en = 1'b1;
        tick(5);
        disable_seq();                      // abort in calibration
        enable_seq(3'b000, 3'd7);
        check("R3", "new calibration recaptures", int'(freq_code), 7);
        tick(5);
        check("R9", "ramp in progress", int'(ref_word > 0), 1);
        disable_seq();                      // abort in ramp
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_basic();
        t_durations();
        t_fccm();
        t_fault();
        t_restart();
        t_abort();
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected complete");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule